// File: doc/BRIEF.md
# Duty-Cycled Receiver Listen Sequencer

This block runs a low-power listen loop for a radio receiver. While enabled, it alternates an Idle phase with the receiver off and a receive phase with the receiver requested on. The length of each phase is an 8-bit coefficient multiplied by a coded time unit. The units are counted on a tick input that pulses once per 64 µs base period of a calibrated slow oscillator. The receive phase length already includes the receiver's startup time.

During a receive phase, the sequencer watches two level indications from the receive chain: a signal-strength-over-threshold flag and a sync/address-match flag. An acceptance rule uses them to decide whether a packet has arrived. After acceptance, one of three end actions applies:

- Keep the receiver on indefinitely.
- Wait for payload-ready or timeout, then hand over to a programmed operating mode.
- Wait for payload-ready or timeout, then resume cycling. In this case a one-cycle discard pulse is raised when the next receive phase starts.

The reset defaults of the register bank this block is driven from are: Idle unit code 10, receive unit code 01, Idle coefficient 0xF5, receive coefficient 0x20.

Top module: `listen_seq`

## Requirements
- R1: With `rst` high, or in the clock after `listen_en` is sampled low, `rx_en`, `listen_active`, `mode_sel_valid` and `fifo_flush` are all 0.
- R2: One clock after `listen_en` is first sampled high, the Idle phase begins: `listen_active`=1 and `rx_en`=0.
- R3: The Idle phase lasts `idle_coef` × U(`idle_res`) tick pulses, where U(01)=1, U(10)=64 and U(11)=4096. `rx_en` rises on the clock after the edge that samples the last of those ticks. No clock without `tick` advances the phase.
- R4: The receive phase lasts `rx_coef` × U(`rx_res`) ticks. If no packet is accepted, `rx_en` falls one clock after the last tick and the Idle count restarts from its full length.
- R5: The reserved unit code 00 behaves as 10 for the Idle phase and as 01 for the receive phase.
- R6: During a receive phase, a packet is accepted when `rssi_hit`=1 if `need_sync`=0. If `need_sync`=1, `rssi_hit` and `sync_hit` must both be 1 in the same cycle. `rssi_hit` alone is then ignored and the phase times out normally.
- R7: With `end_sel`=00, after acceptance `rx_en` stays 1 and `listen_active` becomes 0, regardless of further ticks, until `listen_en` is cleared.
- R8: With `end_sel`=01, after acceptance `rx_en` stays 1 and `listen_active` stays 1 until `payload_ready` or `rx_timeout` is sampled. One clock later, `rx_en`=0, `listen_active`=0 and `mode_sel_valid`=1, and `mode_sel` holds the `exit_mode` value sampled with the event. This state is held until `listen_en` is cleared.
- R9: With `end_sel`=10, one clock after `payload_ready` or `rx_timeout`, the block is back in the Idle phase and cycling resumes. `fifo_flush` is 1 for exactly the first clock of the next receive phase and for no later one.
- R10: `end_sel`=11 behaves as 01.
- R11: `rssi_hit` and `sync_hit` during the Idle phase have no effect on phase timing or on acceptance.
- R12: A qualifying packet in a cycle where the receive count has already run out is still accepted; acceptance wins over the phase end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock pulse per 64 µs base period |
| listen_en | input | 1 | Enables the listen loop |
| idle_res | input | 2 | Idle phase unit code |
| idle_coef | input | COEF_W | Idle phase coefficient |
| rx_res | input | 2 | Receive phase unit code |
| rx_coef | input | COEF_W | Receive phase coefficient |
| need_sync | input | 1 | Acceptance also requires sync/address match |
| end_sel | input | 2 | End action after acceptance |
| exit_mode | input | MODE_W | Operating mode requested by end action 01 |
| rssi_hit | input | 1 | Signal strength above threshold |
| sync_hit | input | 1 | Sync/address matched |
| payload_ready | input | 1 | Packet payload complete |
| rx_timeout | input | 1 | Receive timeout event |
| rx_en | output | 1 | Receiver-on request |
| listen_active | output | 1 | Listen cycling in progress |
| mode_sel_valid | output | 1 | Handover mode request valid |
| mode_sel | output | MODE_W | Requested operating mode |
| fifo_flush | output | 1 | Discard buffered data (one clock) |

## Verification
All outputs are decoded from registered state, so every result is due one clock after the input that causes it. A phase ends one clock after the edge that samples its final tick, and an acceptance or end event shows one clock after it is sampled. The bench drives inputs and samples outputs on falling edges. It checks each phase boundary on both sides: the output is still unchanged right after the last tick, and changes exactly one clock later. A period without ticks is also checked, to show that the count is held.

// File: rtl/listen_pkg.sv
`timescale 1ns/1ps
package listen_pkg;

    typedef enum logic [1:0] {
        RES_RSVD = 2'b00,
        RES_BASE = 2'b01,
        RES_MID  = 2'b10,
        RES_LONG = 2'b11
    } res_e;

    typedef enum logic [1:0] {
        END_STAY    = 2'b00,
        END_TO_MODE = 2'b01,
        END_RESUME  = 2'b10,
        END_RSVD    = 2'b11
    } end_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_RX,
        ST_HOLD,
        ST_DRAIN,
        ST_EXIT
    } state_e;

    localparam res_e DEF_IDLE_RES = RES_MID;
    localparam res_e DEF_RX_RES   = RES_BASE;
    localparam end_e DEF_END      = END_TO_MODE;

    localparam int PH_IDLE = 0;
    localparam int PH_RX   = 1;
    localparam int N_PH    = 2;

    function automatic res_e fix_res(input logic [1:0] raw, input res_e dflt);
        return (res_e'(raw) == RES_RSVD) ? dflt : res_e'(raw);
    endfunction

    function automatic end_e fix_end(input logic [1:0] raw);
        return (end_e'(raw) == END_RSVD) ? DEF_END : end_e'(raw);
    endfunction

    function automatic logic state_rx_on(input state_e s);
        return (s == ST_RX) || (s == ST_HOLD) || (s == ST_DRAIN);
    endfunction

    function automatic logic state_cycling(input state_e s);
        return (s == ST_IDLE) || (s == ST_RX) || (s == ST_DRAIN);
    endfunction

endpackage

// File: rtl/listen_cfg_decode.sv
`timescale 1ns/1ps
module listen_cfg_decode
    import listen_pkg::*;
#(
    parameter int COEF_W    = 8,
    parameter int UNIT_MID  = 64,
    parameter int UNIT_LONG = 4096,
    parameter int CNT_W     = COEF_W + $clog2(UNIT_LONG + 1)
) (
    input  logic [1:0]        idle_res,
    input  logic [COEF_W-1:0] idle_coef,
    input  logic [1:0]        rx_res,
    input  logic [COEF_W-1:0] rx_coef,
    input  logic [1:0]        end_sel,
    output logic [CNT_W-1:0]  idle_len,
    output logic [CNT_W-1:0]  rx_len,
    output end_e              end_act
);

    localparam int PAD_W = CNT_W - COEF_W;

    logic [1:0]        raw_res [N_PH];
    logic [COEF_W-1:0] raw_coef[N_PH];
    res_e              dflt_res[N_PH];
    logic [CNT_W-1:0]  len     [N_PH];

    function automatic logic [CNT_W-1:0] unit_of(input res_e r);
        case (r)
            RES_MID:  return CNT_W'(UNIT_MID);
            RES_LONG: return CNT_W'(UNIT_LONG);
            default:  return CNT_W'(1);
        endcase
    endfunction

    assign raw_res[PH_IDLE]  = idle_res;
    assign raw_res[PH_RX]    = rx_res;
    assign raw_coef[PH_IDLE] = idle_coef;
    assign raw_coef[PH_RX]   = rx_coef;
    assign dflt_res[PH_IDLE] = DEF_IDLE_RES;
    assign dflt_res[PH_RX]   = DEF_RX_RES;

    for (genvar g = 0; g < N_PH; g++) begin : g_phase
        res_e eff_res;
        assign eff_res = fix_res(raw_res[g], dflt_res[g]);
        assign len[g]  = {{PAD_W{1'b0}}, raw_coef[g]} * unit_of(eff_res);
    end

    assign idle_len = len[PH_IDLE];
    assign rx_len   = len[PH_RX];
    assign end_act  = fix_end(end_sel);

endmodule

// File: rtl/listen_phase_timer.sv
`timescale 1ns/1ps
module listen_phase_timer #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (tick && (remain_q != '0)) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/listen_seq_fsm.sv
`timescale 1ns/1ps
module listen_seq_fsm
    import listen_pkg::*;
#(
    parameter int CNT_W  = 21,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              listen_en,
    input  logic [CNT_W-1:0]  idle_len,
    input  logic [CNT_W-1:0]  rx_len,
    input  end_e              end_act,
    input  logic              need_sync,
    input  logic [MODE_W-1:0] exit_mode,
    input  logic              rssi_hit,
    input  logic              sync_hit,
    input  logic              payload_ready,
    input  logic              rx_timeout,
    input  logic              expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              rx_en,
    output logic              listen_active,
    output logic              mode_sel_valid,
    output logic [MODE_W-1:0] mode_sel,
    output logic              fifo_flush
);

    state_e            st_q, st_d;
    end_e              end_q;
    logic              flush_pend_q;
    logic              flush_q;
    logic [MODE_W-1:0] mode_q;
    logic              accept;
    logic              done_evt;

    assign accept   = rssi_hit && (!need_sync || sync_hit);
    assign done_evt = payload_ready || rx_timeout;

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = idle_len;
        if (!listen_en) begin
            st_d = ST_OFF;
        end else begin
            case (st_q)
                ST_OFF: begin
                    st_d     = ST_IDLE;
                    tmr_load = 1'b1;
                    tmr_val  = idle_len;
                end
                ST_IDLE: begin
                    if (expired) begin
                        st_d     = ST_RX;
                        tmr_load = 1'b1;
                        tmr_val  = rx_len;
                    end
                end
                ST_RX: begin
                    if (accept) begin
                        st_d = (end_act == END_STAY) ? ST_HOLD : ST_DRAIN;
                    end else if (expired) begin
                        st_d     = ST_IDLE;
                        tmr_load = 1'b1;
                        tmr_val  = idle_len;
                    end
                end
                ST_DRAIN: begin
                    if (done_evt) begin
                        if (end_q == END_RESUME) begin
                            st_d     = ST_IDLE;
                            tmr_load = 1'b1;
                            tmr_val  = idle_len;
                        end else begin
                            st_d = ST_EXIT;
                        end
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_OFF;
            end_q        <= DEF_END;
            flush_pend_q <= 1'b0;
            flush_q      <= 1'b0;
            mode_q       <= '0;
        end else begin
            st_q    <= st_d;
            flush_q <= 1'b0;
            if (st_q == ST_RX && st_d != ST_RX && st_d != ST_IDLE) begin
                end_q <= end_act;
            end
            if (st_q == ST_DRAIN && st_d == ST_EXIT) begin
                mode_q <= exit_mode;
            end
            if (st_d == ST_OFF) begin
                flush_pend_q <= 1'b0;
            end else if (st_q == ST_DRAIN && st_d == ST_IDLE) begin
                flush_pend_q <= 1'b1;
            end else if (st_q == ST_IDLE && st_d == ST_RX) begin
                flush_q      <= flush_pend_q;
                flush_pend_q <= 1'b0;
            end
        end
    end

    assign rx_en          = state_rx_on(st_q);
    assign listen_active  = state_cycling(st_q);
    assign mode_sel_valid = (st_q == ST_EXIT);
    assign mode_sel       = (st_q == ST_EXIT) ? mode_q : '0;
    assign fifo_flush     = flush_q;

endmodule

// File: rtl/listen_seq.sv
`timescale 1ns/1ps
module listen_seq
    import listen_pkg::*;
#(
    parameter int COEF_W    = 8,
    parameter int MODE_W    = 3,
    parameter int UNIT_MID  = 64,
    parameter int UNIT_LONG = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              listen_en,
    input  logic [1:0]        idle_res,
    input  logic [COEF_W-1:0] idle_coef,
    input  logic [1:0]        rx_res,
    input  logic [COEF_W-1:0] rx_coef,
    input  logic              need_sync,
    input  logic [1:0]        end_sel,
    input  logic [MODE_W-1:0] exit_mode,
    input  logic              rssi_hit,
    input  logic              sync_hit,
    input  logic              payload_ready,
    input  logic              rx_timeout,
    output logic              rx_en,
    output logic              listen_active,
    output logic              mode_sel_valid,
    output logic [MODE_W-1:0] mode_sel,
    output logic              fifo_flush
);

    localparam int CNT_W = COEF_W + $clog2(UNIT_LONG + 1);

    logic [CNT_W-1:0] idle_len, rx_len, tmr_val;
    end_e             end_act;
    logic             tmr_load, expired;

    listen_cfg_decode #(
        .COEF_W(COEF_W), .UNIT_MID(UNIT_MID),
        .UNIT_LONG(UNIT_LONG), .CNT_W(CNT_W)
    ) u_cfg (
        .idle_res (idle_res),
        .idle_coef(idle_coef),
        .rx_res   (rx_res),
        .rx_coef  (rx_coef),
        .end_sel  (end_sel),
        .idle_len (idle_len),
        .rx_len   (rx_len),
        .end_act  (end_act)
    );

    listen_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .tick    (tick),
        .expired (expired)
    );

    listen_seq_fsm #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .listen_en     (listen_en),
        .idle_len      (idle_len),
        .rx_len        (rx_len),
        .end_act       (end_act),
        .need_sync     (need_sync),
        .exit_mode     (exit_mode),
        .rssi_hit      (rssi_hit),
        .sync_hit      (sync_hit),
        .payload_ready (payload_ready),
        .rx_timeout    (rx_timeout),
        .expired       (expired),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .rx_en         (rx_en),
        .listen_active (listen_active),
        .mode_sel_valid(mode_sel_valid),
        .mode_sel      (mode_sel),
        .fifo_flush    (fifo_flush)
    );

endmodule

// File: rtl/listen_seq_chk.sv
`timescale 1ns/1ps
module listen_seq_chk (
    input logic clk,
    input logic rst,
    input logic listen_en,
    input logic payload_ready,
    input logic rx_timeout,
    input logic rx_en,
    input logic listen_active,
    input logic mode_sel_valid,
    input logic fifo_flush
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rx_en && !listen_active && !mode_sel_valid && !fifo_flush));

    a_r1_disable_quiet: assert property (@(posedge clk) disable iff (rst)
        !listen_en |=> (!rx_en && !listen_active && !mode_sel_valid && !fifo_flush));

    a_r2_enable_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(listen_en) |=> (listen_active && !rx_en));

    a_r8_mode_after_event: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_sel_valid) |-> $past(payload_ready || rx_timeout));

    a_r8_mode_rx_off: assert property (@(posedge clk) disable iff (rst)
        mode_sel_valid |-> (!rx_en && !listen_active));

    a_r9_flush_in_rx: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> (rx_en && listen_active));

    a_r9_flush_single: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |=> !fifo_flush);

endmodule

bind listen_seq listen_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .listen_en     (listen_en),
    .payload_ready (payload_ready),
    .rx_timeout    (rx_timeout),
    .rx_en         (rx_en),
    .listen_active (listen_active),
    .mode_sel_valid(mode_sel_valid),
    .fifo_flush    (fifo_flush)
);

// File: tb/listen_seq_tb.sv
`timescale 1ns/1ps
module listen_seq_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, listen_en = 1'b0;
    logic [1:0] idle_res = 2'b01, rx_res = 2'b01, end_sel = 2'b00;
    logic [7:0] idle_coef = 8'd1, rx_coef = 8'd2;
    logic       need_sync = 1'b0;
    logic [2:0] exit_mode = 3'd0;
    logic       rssi_hit = 1'b0, sync_hit = 1'b0, payload_ready = 1'b0, rx_timeout = 1'b0;
    logic       rx_en, listen_active, mode_sel_valid, fifo_flush;
    logic [2:0] mode_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    listen_seq u_dut (
        .clk(clk), .rst(rst), .tick(tick), .listen_en(listen_en),
        .idle_res(idle_res), .idle_coef(idle_coef),
        .rx_res(rx_res), .rx_coef(rx_coef),
        .need_sync(need_sync), .end_sel(end_sel), .exit_mode(exit_mode),
        .rssi_hit(rssi_hit), .sync_hit(sync_hit),
        .payload_ready(payload_ready), .rx_timeout(rx_timeout),
        .rx_en(rx_en), .listen_active(listen_active),
        .mode_sel_valid(mode_sel_valid), .mode_sel(mode_sel),
        .fifo_flush(fifo_flush)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        tick = 1'b1;
        step(n);
        tick = 1'b0;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // restart the loop with a 1-tick Idle phase and land in the receive phase
    task automatic enter_rx();
        idle_res  = 2'b01;
        idle_coef = 8'd1;
        listen_en = 1'b0;
        step(1);
        listen_en = 1'b1;
        step(1);
        tick_n(1);
        step(1);
        chk("R3", "rx_en entering rx", int'(rx_en), 1);
    endtask

    task automatic accept_pulse(input logic with_sync);
        rssi_hit = 1'b1;
        sync_hit = with_sync;
        step(1);
        rssi_hit = 1'b0;
        sync_hit = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(3);
        chk("R1", "rx_en in reset", int'(rx_en), 0);
        chk("R1", "listen_active in reset", int'(listen_active), 0);
        rst = 1'b0;
        step(2);
        chk("R1", "mode_sel_valid idle", int'(mode_sel_valid), 0);
        chk("R1", "fifo_flush idle", int'(fifo_flush), 0);
    endtask

    task automatic t_base_timing();
        idle_res = 2'b01; idle_coef = 8'd3;
        rx_res = 2'b01; rx_coef = 8'd2;
        listen_en = 1'b1;
        step(1);
        chk("R2", "listen_active after enable", int'(listen_active), 1);
        chk("R2", "rx_en after enable", int'(rx_en), 0);
        tick_n(2);
        step(3);
        chk("R3", "rx_en held without ticks", int'(rx_en), 0);
        tick_n(1);
        chk("R3", "rx_en right after last idle tick", int'(rx_en), 0);
        step(1);
        chk("R3", "rx_en one clock after last idle tick", int'(rx_en), 1);
        tick_n(2);
        chk("R4", "rx_en right after last rx tick", int'(rx_en), 1);
        step(1);
        chk("R4", "rx_en after rx phase", int'(rx_en), 0);
        chk("R4", "listen_active back in idle", int'(listen_active), 1);
        tick_n(2);
        step(1);
        chk("R4", "idle count reloaded", int'(rx_en), 0);
        tick_n(1);
        step(1);
        chk("R4", "rx after reloaded idle", int'(rx_en), 1);
    endtask

    task automatic t_scaling();
        rx_res = 2'b01; rx_coef = 8'd2;
        idle_res = 2'b10; idle_coef = 8'd2;
        listen_en = 1'b0; step(1); listen_en = 1'b1; step(1);
        tick_n(127);
        step(1);
        chk("R3", "unit 10: rx_en after 127 ticks", int'(rx_en), 0);
        tick_n(1);
        step(1);
        chk("R3", "unit 10: rx_en after 128 ticks", int'(rx_en), 1);
        idle_res = 2'b11; idle_coef = 8'd1;
        listen_en = 1'b0; step(1); listen_en = 1'b1; step(1);
        tick_n(4095);
        step(1);
        chk("R3", "unit 11: rx_en after 4095 ticks", int'(rx_en), 0);
        tick_n(1);
        step(1);
        chk("R3", "unit 11: rx_en after 4096 ticks", int'(rx_en), 1);
        rx_res = 2'b10; rx_coef = 8'd1;
        enter_rx();
        tick_n(63);
        step(1);
        chk("R4", "rx unit 10: rx_en after 63 ticks", int'(rx_en), 1);
        tick_n(1);
        step(1);
        chk("R4", "rx unit 10: rx_en after 64 ticks", int'(rx_en), 0);
    endtask

    task automatic t_reserved_res();
        rx_res = 2'b00; rx_coef = 8'd3;
        idle_res = 2'b00; idle_coef = 8'd1;
        listen_en = 1'b0; step(1); listen_en = 1'b1; step(1);
        tick_n(63);
        step(1);
        chk("R5", "idle code 00: rx_en after 63 ticks", int'(rx_en), 0);
        tick_n(1);
        step(1);
        chk("R5", "idle code 00: rx_en after 64 ticks", int'(rx_en), 1);
        tick_n(2);
        step(1);
        chk("R5", "rx code 00: rx_en after 2 ticks", int'(rx_en), 1);
        tick_n(1);
        step(1);
        chk("R5", "rx code 00: rx_en after 3 ticks", int'(rx_en), 0);
    endtask

    task automatic t_crit_and_stay();
        rx_res = 2'b01; rx_coef = 8'd2;
        end_sel = 2'b00; need_sync = 1'b0;
        enter_rx();
        accept_pulse(1'b0);
        tick_n(6);
        step(2);
        chk("R6", "rssi alone accepted, rx_en", int'(rx_en), 1);
        chk("R7", "stay: listen_active", int'(listen_active), 0);
        listen_en = 1'b0;
        step(1);
        chk("R1", "rx_en after disable from stay", int'(rx_en), 0);
        need_sync = 1'b1;
        enter_rx();
        accept_pulse(1'b0);
        tick_n(2);
        step(1);
        chk("R6", "rssi without sync ignored, rx_en", int'(rx_en), 0);
        chk("R6", "rssi without sync ignored, active", int'(listen_active), 1);
        tick_n(1);
        step(1);
        accept_pulse(1'b1);
        tick_n(6);
        step(2);
        chk("R6", "rssi+sync accepted, rx_en", int'(rx_en), 1);
        chk("R7", "stay after rssi+sync: listen_active", int'(listen_active), 0);
        need_sync = 1'b0;
    endtask

    task automatic t_to_mode(input logic [1:0] code, input string req);
        end_sel = code;
        exit_mode = 3'd5;
        rx_res = 2'b01; rx_coef = 8'd2;
        enter_rx();
        accept_pulse(1'b0);
        tick_n(8);
        step(2);
        chk(req, "waiting: rx_en", int'(rx_en), 1);
        chk(req, "waiting: listen_active", int'(listen_active), 1);
        chk(req, "waiting: mode_sel_valid", int'(mode_sel_valid), 0);
        if (code == 2'b01) payload_ready = 1'b1; else rx_timeout = 1'b1;
        step(1);
        payload_ready = 1'b0; rx_timeout = 1'b0;
        exit_mode = 3'd2;
        chk(req, "handover: rx_en", int'(rx_en), 0);
        chk(req, "handover: mode_sel_valid", int'(mode_sel_valid), 1);
        chk(req, "handover: listen_active", int'(listen_active), 0);
        tick_n(4);
        step(2);
        chk(req, "handover: mode_sel held", int'(mode_sel), 5);
        listen_en = 1'b0;
        step(1);
        chk("R1", "mode_sel_valid after disable", int'(mode_sel_valid), 0);
    endtask

    task automatic t_resume();
        end_sel = 2'b10;
        rx_res = 2'b01; rx_coef = 8'd2;
        enter_rx();
        accept_pulse(1'b0);
        step(3);
        rx_timeout = 1'b1;
        step(1);
        rx_timeout = 1'b0;
        chk("R9", "resume: rx_en", int'(rx_en), 0);
        chk("R9", "resume: listen_active", int'(listen_active), 1);
        chk("R9", "resume: no flush yet", int'(fifo_flush), 0);
        tick_n(1);
        step(1);
        chk("R9", "next rx: rx_en", int'(rx_en), 1);
        chk("R9", "next rx: fifo_flush first clock", int'(fifo_flush), 1);
        step(1);
        chk("R9", "next rx: fifo_flush second clock", int'(fifo_flush), 0);
        tick_n(2);
        step(1);
        chk("R9", "cycling resumed: rx ended", int'(rx_en), 0);
        tick_n(1);
        step(1);
        chk("R9", "later rx: no flush", int'(fifo_flush), 0);
    endtask

    task automatic t_idle_ignore();
        end_sel = 2'b00; need_sync = 1'b0;
        idle_res = 2'b01; idle_coef = 8'd3;
        rx_res = 2'b01; rx_coef = 8'd2;
        listen_en = 1'b0; step(1); listen_en = 1'b1; step(1);
        rssi_hit = 1'b1; sync_hit = 1'b1;
        step(2);
        rssi_hit = 1'b0; sync_hit = 1'b0;
        chk("R11", "idle hit: rx_en", int'(rx_en), 0);
        tick_n(3);
        step(1);
        chk("R11", "idle timing kept", int'(rx_en), 1);
        tick_n(2);
        step(1);
        chk("R11", "no acceptance from idle hit", int'(rx_en), 0);
    endtask

    task automatic t_precedence();
        end_sel = 2'b00;
        rx_res = 2'b01; rx_coef = 8'd1;
        enter_rx();
        tick_n(1);
        accept_pulse(1'b0);
        step(3);
        chk("R12", "accept wins over phase end: rx_en", int'(rx_en), 1);
        chk("R12", "accept wins: listen_active", int'(listen_active), 0);
        listen_en = 1'b0;
        step(1);
    endtask

    task automatic t_disable();
        rx_res = 2'b01; rx_coef = 8'd5;
        end_sel = 2'b01;
        enter_rx();
        listen_en = 1'b0;
        step(1);
        chk("R1", "disable in rx: rx_en", int'(rx_en), 0);
        chk("R1", "disable in rx: listen_active", int'(listen_active), 0);
        enter_rx();
        accept_pulse(1'b0);
        listen_en = 1'b0;
        step(1);
        chk("R1", "disable while waiting: rx_en", int'(rx_en), 0);
    endtask

    initial begin
        step(1);
        t_reset();
        t_base_timing();
        t_scaling();
        t_reserved_res();
        t_crit_and_stay();
        t_to_mode(2'b01, "R8");
        t_to_mode(2'b11, "R10");
        t_resume();
        t_idle_ignore();
        t_precedence();
        t_disable();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule